// File: doc/BRIEF.md
# Permission-Checked Register Bank

This block is a small register file for a network controller. It sits on a simple request/response bus. Each word address is checked against an access class: read-write, read-only, write-only or undecoded. A request that breaks the rules for its class completes with an error flag and has no effect. A power-down bit lives in a register of its own. While the bit is set, the bank refuses every access except those to that register, so software can always wake it up again.

A request is one cycle with `req_i` high. Its response comes in the next cycle: `ready_o` is high for one cycle, and `err_o` and `rdata_o` are valid in that same cycle. Requests may arrive on consecutive cycles. The scratch registers are plain storage. The write-only register is a bit-clear command aimed at the first scratch register. The read-only registers give a fixed identity value and a live status input.

Top module: `regbank_guard`

## Requirements
- R1: After reset, `pwrdn_o` is low and every scratch register reads zero.
- R2: `ready_o` is high in the cycle directly after each cycle with `req_i` high. It is low in the cycle after a cycle with `req_i` low.
- R3: Word offsets 2 and 3 are scratch registers. A write stores all 32 bits, and a read returns the stored value with `err_o` low.
- R4: Offset 0 reads as the parameter `ID_VALUE`, and offset 1 reads as `status_i` as it was in the request cycle. A write to either offset returns `err_o` high.
- R5: Offset 4 is write-only. A write to it clears each bit of the offset-2 scratch register where `wdata_i` is 1. A read of it returns `err_o` high.
- R6: Offsets 5, 6 and 8 to 15 are undecoded. Any read or write there returns `err_o` high.
- R7: A response with `err_o` high carries `rdata_o` equal to zero, and an errored write leaves every register unchanged.
- R8: Offset 7 holds the power-down bit in bit 0; its other bits read zero. While the bit is 1, every access to any other offset returns `err_o` high. Accesses to offset 7 complete normally.
- R9: Writing 0 to bit 0 of offset 7 clears the power-down bit, and the very next request to any register is served normally.
- R10: `pwrdn_o` equals the stored power-down bit.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous active-low reset |
| req_i | input | 1 | Request strobe, one cycle per access |
| addr_i | input | 4 | Word offset |
| we_i | input | 1 | 1 = write, 0 = read |
| wdata_i | input | 32 | Write data |
| status_i | input | 32 | Live value for the read-only status register |
| rdata_o | output | 32 | Read data, valid with ready_o |
| ready_o | output | 1 | Response strobe |
| err_o | output | 1 | Error flag, valid with ready_o |
| pwrdn_o | output | 1 | Power-down level |

## Verification
The bench writes to read-only registers and reads write-only and undecoded offsets. After each of these it reads back the neighbouring scratch contents. A design that let an errored write through would show corrupted scratch data, and one that leaked the mux output on an error would return nonzero data. Power-down is exercised in both directions: a design that also gated its own register could never wake up, and one that held the bit for an extra cycle would wrongly error the first request after the bit is cleared. Back-to-back requests expose a response stage that stretches or drops `ready_o`.

// File: rtl/regbank_pkg.sv
package regbank_pkg;
  typedef enum logic [2:0] {
    ACC_RW   = 3'd0,
    ACC_RO   = 3'd1,
    ACC_WO   = 3'd2,
    ACC_PD   = 3'd3,
    ACC_NONE = 3'd4
  } acc_e;
endpackage

// File: rtl/regbank_decode.sv
module regbank_decode
  import regbank_pkg::*;
#(
  parameter int AW       = 4,
  parameter int NUM_SCR  = 2,
  parameter int ID_OFF   = 0,
  parameter int STAT_OFF = 1,
  parameter int SCR_BASE = 2,
  parameter int CLR_OFF  = 4,
  parameter int PD_OFF   = 7
) (
  input  logic [AW-1:0]      addr_i,
  output acc_e               cls_o,
  output logic [NUM_SCR-1:0] sel_scr_o,
  output logic               sel_id_o,
  output logic               sel_stat_o,
  output logic               sel_clr_o,
  output logic               sel_pd_o
);
  for (genvar i = 0; i < NUM_SCR; i++) begin : g_scr
    assign sel_scr_o[i] = (addr_i == AW'(SCR_BASE + i));
  end

  assign sel_id_o   = (addr_i == AW'(ID_OFF));
  assign sel_stat_o = (addr_i == AW'(STAT_OFF));
  assign sel_clr_o  = (addr_i == AW'(CLR_OFF));
  assign sel_pd_o   = (addr_i == AW'(PD_OFF));

  always_comb begin
    cls_o = ACC_NONE;
    if (|sel_scr_o)              cls_o = ACC_RW;
    if (sel_id_o || sel_stat_o)  cls_o = ACC_RO;
    if (sel_clr_o)               cls_o = ACC_WO;
    if (sel_pd_o)                cls_o = ACC_PD;
  end
endmodule

// File: rtl/regbank_store.sv
module regbank_store #(
  parameter int DW      = 32,
  parameter int NUM_SCR = 2
) (
  input  logic                        clk_i,
  input  logic                        rst_ni,
  input  logic [NUM_SCR-1:0]          wr_scr_i,
  input  logic                        wr_clr_i,
  input  logic                        wr_pd_i,
  input  logic [DW-1:0]               wdata_i,
  output logic [NUM_SCR-1:0][DW-1:0]  scr_o,
  output logic                        pd_o
);
  logic [NUM_SCR-1:0][DW-1:0] scr_q;
  logic                       pd_q;

  for (genvar i = 0; i < NUM_SCR; i++) begin : g_reg
    always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni)          scr_q[i] <= '0;
      else if (wr_scr_i[i]) scr_q[i] <= wdata_i;
      else if (i == 0 && wr_clr_i) scr_q[i] <= scr_q[i] & ~wdata_i;  // bit-clear command
    end
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)      pd_q <= 1'b0;
    else if (wr_pd_i) pd_q <= wdata_i[0];
  end

  assign scr_o = scr_q;
  assign pd_o  = pd_q;

  // R7
  scr_hold_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!(|wr_scr_i) && !wr_clr_i) |=> $stable(scr_q));
  // R8
  pd_hold_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !wr_pd_i |=> $stable(pd_q));
endmodule

// File: rtl/regbank_guard.sv
module regbank_guard
  import regbank_pkg::*;
#(
  parameter int          AW       = 4,
  parameter int          DW       = 32,
  parameter int          NUM_SCR  = 2,
  parameter int          PD_OFF   = 7,
  parameter logic [DW-1:0] ID_VALUE = 32'h5A17_0001
) (
  input  logic          clk_i,
  input  logic          rst_ni,
  input  logic          req_i,
  input  logic [AW-1:0] addr_i,
  input  logic          we_i,
  input  logic [DW-1:0] wdata_i,
  input  logic [DW-1:0] status_i,
  output logic [DW-1:0] rdata_o,
  output logic          ready_o,
  output logic          err_o,
  output logic          pwrdn_o
);
  localparam int ID_OFF   = 0;
  localparam int STAT_OFF = 1;
  localparam int SCR_BASE = 2;
  localparam int CLR_OFF  = SCR_BASE + NUM_SCR;

  acc_e                       cls;
  logic [NUM_SCR-1:0]         sel_scr;
  logic                       sel_id, sel_stat, sel_clr, sel_pd;
  logic [NUM_SCR-1:0][DW-1:0] scr;
  logic                       pd;
  logic                       bad;
  logic [DW-1:0]              rd;

  regbank_decode #(
    .AW(AW), .NUM_SCR(NUM_SCR), .ID_OFF(ID_OFF), .STAT_OFF(STAT_OFF),
    .SCR_BASE(SCR_BASE), .CLR_OFF(CLR_OFF), .PD_OFF(PD_OFF)
  ) u_dec (
    .addr_i    (addr_i),
    .cls_o     (cls),
    .sel_scr_o (sel_scr),
    .sel_id_o  (sel_id),
    .sel_stat_o(sel_stat),
    .sel_clr_o (sel_clr),
    .sel_pd_o  (sel_pd)
  );

  // permission check
  always_comb begin
    bad = 1'b0;
    unique case (cls)
      ACC_NONE: bad = 1'b1;
      ACC_RO:   bad = we_i;
      ACC_WO:   bad = !we_i;
      default:  bad = 1'b0;
    endcase
    if (pd && cls != ACC_PD) bad = 1'b1;
  end

  logic wr_ok;
  assign wr_ok = req_i && we_i && !bad;

  regbank_store #(.DW(DW), .NUM_SCR(NUM_SCR)) u_store (
    .clk_i   (clk_i),
    .rst_ni  (rst_ni),
    .wr_scr_i(sel_scr & {NUM_SCR{wr_ok}}),
    .wr_clr_i(sel_clr && wr_ok),
    .wr_pd_i (sel_pd && wr_ok),
    .wdata_i (wdata_i),
    .scr_o   (scr),
    .pd_o    (pd)
  );

  always_comb begin
    rd = '0;
    if (sel_id)   rd = ID_VALUE;
    if (sel_stat) rd = status_i;
    for (int i = 0; i < NUM_SCR; i++) if (sel_scr[i]) rd = scr[i];
    if (sel_pd)   rd = DW'(pd);
    if (bad || we_i) rd = '0;
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      ready_o <= 1'b0;
      err_o   <= 1'b0;
      rdata_o <= '0;
    end else begin
      ready_o <= req_i;
      err_o   <= req_i && bad;
      rdata_o <= req_i ? rd : '0;
    end
  end

  assign pwrdn_o = pd;

  // R2
  ready_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    req_i |=> ready_o);
  // R2
  idle_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !req_i |=> !ready_o);
  // R7
  err_zero_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    err_o |-> (rdata_o == '0));
  // R8
  pd_block_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (pwrdn_o && req_i && addr_i != AW'(PD_OFF)) |=> err_o);
  // R4
  ro_write_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (req_i && we_i && addr_i == AW'(ID_OFF)) |=> err_o);
  // R5
  wo_read_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (req_i && !we_i && addr_i == AW'(CLR_OFF)) |=> (err_o && rdata_o == '0));
endmodule

// File: tb/regbank_guard_bench.sv
module regbank_guard_bench;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        req = 1'b0;
  logic [3:0]  addr = '0;
  logic        we = 1'b0;
  logic [31:0] wdata = '0;
  logic [31:0] status = 32'hC0DE_1234;
  logic [31:0] rdata_o;
  logic        ready_o, err_o, pwrdn_o;

  int total = 0;
  int bad = 0;
  logic        r_rdy, r_err;
  logic [31:0] r_data;

  localparam logic [31:0] ID = 32'h5A17_0001;

  always #4 clk = ~clk;

  regbank_guard u_regbank_guard (
    .clk_i(clk), .rst_ni(rst_n), .req_i(req), .addr_i(addr), .we_i(we),
    .wdata_i(wdata), .status_i(status), .rdata_o(rdata_o),
    .ready_o(ready_o), .err_o(err_o), .pwrdn_o(pwrdn_o)
  );

  task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
    total++;
    if (act !== exp) begin
      bad++;
      $display("FAIL %s act=%h exp=%h", tag, act, exp);
    end
  endtask

  task automatic acc(input logic [3:0] a, input logic w, input logic [31:0] d);
    @(negedge clk);
    req = 1'b1; addr = a; we = w; wdata = d;
    @(negedge clk);
    req = 1'b0; we = 1'b0;
    r_rdy = ready_o; r_err = err_o; r_data = rdata_o;
    chk("R2 ready", {31'b0, r_rdy}, 32'd1);
  endtask

  task automatic t_reset();
    chk("R1 pwrdn", {31'b0, pwrdn_o}, 32'd0);
    acc(4'd2, 1'b0, '0); chk("R1 scr0", r_data, 32'd0);
    acc(4'd3, 1'b0, '0); chk("R1 scr1", r_data, 32'd0);
  endtask

  task automatic t_rw();
    acc(4'd2, 1'b1, 32'hDEAD_BEEF); chk("R3 wr err", {31'b0, r_err}, 32'd0);
    acc(4'd3, 1'b1, 32'h1357_9BDF);
    acc(4'd2, 1'b0, '0); chk("R3 scr0", r_data, 32'hDEAD_BEEF);
    acc(4'd3, 1'b0, '0); chk("R3 scr1", r_data, 32'h1357_9BDF);
    chk("R3 rd err", {31'b0, r_err}, 32'd0);
    @(negedge clk); chk("R2 idle", {31'b0, ready_o}, 32'd0);
  endtask

  task automatic t_ro();
    acc(4'd0, 1'b0, '0); chk("R4 id", r_data, ID);
    acc(4'd1, 1'b0, '0); chk("R4 status", r_data, 32'hC0DE_1234);
    acc(4'd0, 1'b1, 32'hFFFF_FFFF); chk("R4 wr id err", {31'b0, r_err}, 32'd1);
    acc(4'd1, 1'b1, 32'h0); chk("R4 wr stat err", {31'b0, r_err}, 32'd1);
    acc(4'd0, 1'b0, '0); chk("R4 id kept", r_data, ID);
  endtask

  task automatic t_wo();
    acc(4'd4, 1'b0, '0);
    chk("R5 rd err", {31'b0, r_err}, 32'd1);
    chk("R7 rd zero", r_data, 32'd0);
    acc(4'd4, 1'b1, 32'h0000_FFFF); chk("R5 wr ok", {31'b0, r_err}, 32'd0);
    acc(4'd2, 1'b0, '0); chk("R5 cleared", r_data, 32'hDEAD_0000);
    acc(4'd3, 1'b0, '0); chk("R5 scr1 kept", r_data, 32'h1357_9BDF);
  endtask

  task automatic t_reserved();
    logic [3:0] offs [4] = '{4'd5, 4'd6, 4'd8, 4'd15};
    for (int i = 0; i < 4; i++) begin
      acc(offs[i], 1'b0, '0);
      chk("R6 rd err", {31'b0, r_err}, 32'd1);
      chk("R7 rd zero", r_data, 32'd0);
      acc(offs[i], 1'b1, 32'hFFFF_FFFF);
      chk("R6 wr err", {31'b0, r_err}, 32'd1);
    end
    acc(4'd2, 1'b0, '0); chk("R7 scr0 kept", r_data, 32'hDEAD_0000);
    chk("R7 pd kept", {31'b0, pwrdn_o}, 32'd0);
  endtask

  task automatic t_pd();
    acc(4'd7, 1'b1, 32'hFFFF_FFFF); chk("R8 pd wr ok", {31'b0, r_err}, 32'd0);
    chk("R10 pwrdn", {31'b0, pwrdn_o}, 32'd1);
    acc(4'd7, 1'b0, '0); chk("R8 pd rd", r_data, 32'd1);
    chk("R8 pd rd err", {31'b0, r_err}, 32'd0);
    acc(4'd2, 1'b0, '0); chk("R8 blk rd", {31'b0, r_err}, 32'd1);
    chk("R8 blk zero", r_data, 32'd0);
    acc(4'd0, 1'b0, '0); chk("R8 blk id", {31'b0, r_err}, 32'd1);
    acc(4'd2, 1'b1, 32'h1111_1111); chk("R8 blk wr", {31'b0, r_err}, 32'd1);
    acc(4'd4, 1'b1, 32'hFFFF_FFFF); chk("R8 blk clr", {31'b0, r_err}, 32'd1);
    acc(4'd7, 1'b1, 32'h0); chk("R9 clear ok", {31'b0, r_err}, 32'd0);
    chk("R10 pwrdn low", {31'b0, pwrdn_o}, 32'd0);
    acc(4'd2, 1'b0, '0);
    chk("R9 next ok", {31'b0, r_err}, 32'd0);
    chk("R9 scr0 intact", r_data, 32'hDEAD_0000);
  endtask

  task automatic t_b2b();
    @(negedge clk); req = 1'b1; addr = 4'd3; we = 1'b0;
    @(negedge clk);
    chk("R2 b2b rdy1", {31'b0, ready_o}, 32'd1);
    chk("R3 b2b d1", rdata_o, 32'h1357_9BDF);
    addr = 4'd0;
    @(negedge clk); req = 1'b0;
    chk("R2 b2b rdy2", {31'b0, ready_o}, 32'd1);
    chk("R4 b2b d2", rdata_o, ID);
    @(negedge clk); chk("R2 b2b idle", {31'b0, ready_o}, 32'd0);
  endtask

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    t_reset();
    t_rw();
    t_ro();
    t_wo();
    t_reserved();
    t_pd();
    t_b2b();
    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin
    repeat (20000) @(posedge clk);
    total++; bad++;
    $display("FAIL watchdog act=%h exp=%h", 32'd0, 32'd1);
    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule